// File: doc/BRIEF.md
# Monotonic Security Level Controller

This block keeps the security level of a contactless card, a value from 0 to 3 that starts at 0 after delivery. The level can only rise. The block records which of the mandatory personalization keys have been written. It performs the commit that ends personalization and raises the level after the authentication layer reports a successful switch-key authentication. From the current level it derives the enables that tell the protocol layer which protocol, and which command scope, may be used.

A strap input sets the card variant: a first-level card or a third-level-only card. The strap chooses where a commit lands and which keys the commit needs. Non-volatile storage of the level and the authentication itself are outside this block. Every commit or switch request gets exactly one registered verdict.

Top module: `seclvl_ctrl`

## Requirements
- R1: After reset the level is 0, no key is marked as written, and `resp_vld` and `resp_ok` are low.
- R2: The level never decreases. A request whose target is equal to or below the current level is rejected and leaves the level unchanged.
- R3: A commit at level 0 is accepted when every required key is marked. With `l3_card`=0 the level moves to 1. With `l3_card`=1 it moves straight to 3.
- R4: Key identifiers are 0 = card configuration key, 1 = card master key, 2 = level-2 switch key, 3 = level-3 switch key. A commit needs keys 0 and 1 on both card variants, and also keys 2 and 3 when `l3_card`=0. A commit with any required key missing is rejected.
- R5: With `l3_card`=0, a switch request is accepted only when the current level is at least 1, the target is 2 or 3, and the target is above the current level. The level then takes the target.
- R6: With `l3_card`=1, every switch request is rejected, and the level never takes the value 1 or 2.
- R7: `key_wr_vld` sets bit `key_wr_id` of `key_have`, and the bit stays set. Identifiers at or above NUM_KEYS are ignored. Key writes are ignored when the level is above 0.
- R8: `resp_vld` is high for exactly the one cycle after each cycle with `commit_req` or `sw_auth_ok` high. `resp_ok` in that cycle tells whether the request was accepted. If both strobes are high in the same cycle, a single rejection is given and nothing changes.
- R9: `block_en` is always high and `legacy_en` is high at levels 0 to 2. `blk_keyupd_en` (key and configuration updates over the block protocol) is high at levels 0, 2 and 3. `blk_full_en` (the full block-protocol command set) is high at levels 0 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| l3_card | input | 1 | Card-variant strap, 1 = third-level-only card; static while out of reset |
| key_wr_vld | input | 1 | A key has been personalized this cycle |
| key_wr_id | input | KEY_ID_W | Identifier of the written key |
| commit_req | input | 1 | Commit-personalization request strobe |
| sw_auth_ok | input | 1 | Successful switch-key authentication strobe |
| sw_auth_lvl | input | 2 | Target level of the switch authentication |
| level | output | 2 | Current security level |
| key_have | output | NUM_KEYS | Sticky written-key flags |
| resp_vld | output | 1 | Verdict valid for the previous cycle's request |
| resp_ok | output | 1 | 1 = request accepted, 0 = rejected |
| legacy_en | output | 1 | Legacy frame protocol allowed |
| block_en | output | 1 | Block-oriented protocol allowed |
| blk_keyupd_en | output | 1 | Key and configuration updates allowed over the block protocol |
| blk_full_en | output | 1 | Full block-protocol command set allowed |

## Verification
A strobe sampled at a rising edge changes `level`, `key_have`, `resp_vld` and `resp_ok` at that same edge, so all of them are due one cycle after the strobe. The protocol enables follow `level` combinationally in that same cycle. The bench drives inputs on the falling edge, holds each strobe for a single cycle, and reads every result at the next falling edge, half a period after the capturing edge. The bench reads the idle state one cycle later to confirm that `resp_vld` has dropped.

// File: rtl/seclvl_pkg.sv
package seclvl_pkg;

    localparam int LVL_W = 2;
    typedef logic [LVL_W-1:0] lvl_t;

    localparam lvl_t LVL_PERSO  = 2'd0;
    localparam lvl_t LVL_COMPAT = 2'd1;
    localparam lvl_t LVL_MIXED  = 2'd2;
    localparam lvl_t LVL_AES    = 2'd3;

    // key identifiers whose position the commit rule depends on
    localparam int KEY_CFG   = 0;
    localparam int KEY_MST   = 1;
    localparam int KEY_SW2   = 2;
    localparam int KEY_SW3   = 3;
    localparam int KEY_MANDATORY = 4;

    typedef struct packed {
        lvl_t lvl;
        logic rvld;
        logic rok;
    } ctl_t;

    function automatic lvl_t commit_target(input logic l3);
        return l3 ? LVL_AES : LVL_COMPAT;
    endfunction

endpackage

// File: rtl/seclvl_keyreg.sv
module seclvl_keyreg #(
    parameter int NUM_KEYS = 4,
    parameter int KEY_ID_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [KEY_ID_W-1:0] wr_id,
    output logic [NUM_KEYS-1:0] have
);
    logic [NUM_KEYS-1:0] have_d, have_q;

    always_comb begin
        for (int k = 0; k < NUM_KEYS; k++) begin
            have_d[k] = have_q[k] | (wr_en && (int'(wr_id) == k));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) have_q <= '0;
        else        have_q <= have_d;
    end

    assign have = have_q;
endmodule

// File: rtl/seclvl_judge.sv
module seclvl_judge
    import seclvl_pkg::*;
#(
    parameter int NUM_KEYS = 4
) (
    input  lvl_t                cur_lvl,
    input  logic                l3_card,
    input  logic [NUM_KEYS-1:0] have,
    input  logic                commit_req,
    input  logic                sw_ok,
    input  lvl_t                sw_lvl,
    output logic                any_req,
    output logic                accept,
    output lvl_t                nxt_lvl
);
    logic [NUM_KEYS-1:0] need;
    logic                keys_ok, commit_ok, switch_ok;
    lvl_t                c_tgt;

    // mandatory key set depends on the card variant
    genvar g;
    generate
        for (g = 0; g < NUM_KEYS; g++) begin : g_need
            if (g == KEY_CFG || g == KEY_MST) begin : g_always
                assign need[g] = 1'b1;
            end else if (g == KEY_SW2 || g == KEY_SW3) begin : g_l1only
                assign need[g] = ~l3_card;
            end else begin : g_opt
                assign need[g] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        c_tgt     = commit_target(l3_card);
        keys_ok   = ((have & need) == need);
        commit_ok = keys_ok && (c_tgt > cur_lvl);
        switch_ok = !l3_card && (cur_lvl != LVL_PERSO) &&
                    (sw_lvl >= LVL_MIXED) && (sw_lvl > cur_lvl);
        any_req   = commit_req | sw_ok;
        accept    = 1'b0;
        nxt_lvl   = cur_lvl;
        if (commit_req && sw_ok) begin
            accept = 1'b0;
        end else if (commit_req) begin
            accept = commit_ok;
            if (commit_ok) nxt_lvl = c_tgt;
        end else if (sw_ok) begin
            accept = switch_ok;
            if (switch_ok) nxt_lvl = sw_lvl;
        end
    end
endmodule

// File: rtl/seclvl_protomap.sv
module seclvl_protomap
    import seclvl_pkg::*;
(
    input  lvl_t lvl,
    output logic legacy_en,
    output logic block_en,
    output logic blk_keyupd_en,
    output logic blk_full_en
);
    always_comb begin
        block_en = 1'b1;
        unique case (lvl)
            LVL_PERSO:  begin legacy_en = 1'b1; blk_keyupd_en = 1'b1; blk_full_en = 1'b1; end
            LVL_COMPAT: begin legacy_en = 1'b1; blk_keyupd_en = 1'b0; blk_full_en = 1'b0; end
            LVL_MIXED:  begin legacy_en = 1'b1; blk_keyupd_en = 1'b1; blk_full_en = 1'b0; end
            default:    begin legacy_en = 1'b0; blk_keyupd_en = 1'b1; blk_full_en = 1'b1; end
        endcase
    end
endmodule

// File: rtl/seclvl_ctrl.sv
module seclvl_ctrl
    import seclvl_pkg::*;
#(
    parameter int NUM_KEYS = 4,
    parameter int KEY_ID_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                l3_card,
    input  logic                key_wr_vld,
    input  logic [KEY_ID_W-1:0] key_wr_id,
    input  logic                commit_req,
    input  logic                sw_auth_ok,
    input  logic [1:0]          sw_auth_lvl,
    output logic [1:0]          level,
    output logic [NUM_KEYS-1:0] key_have,
    output logic                resp_vld,
    output logic                resp_ok,
    output logic                legacy_en,
    output logic                block_en,
    output logic                blk_keyupd_en,
    output logic                blk_full_en
);
    ctl_t ctl_d, ctl_q;
    logic any_req, accept;
    lvl_t nxt_lvl;

    seclvl_keyreg #(.NUM_KEYS(NUM_KEYS), .KEY_ID_W(KEY_ID_W)) u_keys (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (key_wr_vld && (ctl_q.lvl == LVL_PERSO)),
        .wr_id (key_wr_id),
        .have  (key_have)
    );

    seclvl_judge #(.NUM_KEYS(NUM_KEYS)) u_judge (
        .cur_lvl    (ctl_q.lvl),
        .l3_card    (l3_card),
        .have       (key_have),
        .commit_req (commit_req),
        .sw_ok      (sw_auth_ok),
        .sw_lvl     (sw_auth_lvl),
        .any_req    (any_req),
        .accept     (accept),
        .nxt_lvl    (nxt_lvl)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.rvld = any_req;
        ctl_d.rok  = any_req && accept;
        if (any_req && accept) ctl_d.lvl = nxt_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{lvl: LVL_PERSO, rvld: 1'b0, rok: 1'b0};
        else        ctl_q <= ctl_d;
    end

    seclvl_protomap u_map (
        .lvl           (ctl_q.lvl),
        .legacy_en     (legacy_en),
        .block_en      (block_en),
        .blk_keyupd_en (blk_keyupd_en),
        .blk_full_en   (blk_full_en)
    );

    assign level    = ctl_q.lvl;
    assign resp_vld = ctl_q.rvld;
    assign resp_ok  = ctl_q.rok;
endmodule

// File: rtl/seclvl_ctrl_chk.sv
module seclvl_ctrl_chk #(
    parameter int NUM_KEYS = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                l3_card,
    input logic                commit_req,
    input logic                sw_auth_ok,
    input logic [1:0]          level,
    input logic [NUM_KEYS-1:0] key_have,
    input logic                resp_vld,
    input logic                resp_ok,
    input logic                legacy_en,
    input logic                block_en
);
    a_r2_never_down: assert property (@(posedge clk) disable iff (!rst_n)
        level >= $past(level));

    a_r2_ok_moves_up: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_vld && resp_ok) |-> (level > $past(level)));

    a_r8_change_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        (level != $past(level)) |-> $past(commit_req || sw_auth_ok));

    a_r8_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_req || sw_auth_ok) |=> resp_vld);

    a_r8_ok_needs_vld: assert property (@(posedge clk) disable iff (!rst_n)
        resp_ok |-> resp_vld);

    a_r6_l3_no_mid: assert property (@(posedge clk) disable iff (!rst_n)
        l3_card |-> (level == 2'd0 || level == 2'd3));

    a_r7_keys_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(key_have) & ~key_have) == '0));

    a_r7_frozen_above0: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(level) != 2'd0) |-> $stable(key_have));

    a_r9_legacy_off_top: assert property (@(posedge clk) disable iff (!rst_n)
        (legacy_en == (level != 2'd3)) && block_en);
endmodule

bind seclvl_ctrl seclvl_ctrl_chk #(.NUM_KEYS(NUM_KEYS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .l3_card    (l3_card),
    .commit_req (commit_req),
    .sw_auth_ok (sw_auth_ok),
    .level      (level),
    .key_have   (key_have),
    .resp_vld   (resp_vld),
    .resp_ok    (resp_ok),
    .legacy_en  (legacy_en),
    .block_en   (block_en)
);

// File: tb/seclvl_ctrl_test.sv
module seclvl_ctrl_test;
    localparam int NK = 4;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l3_card = 1'b0;
    logic key_wr_vld = 1'b0;
    logic [IW-1:0] key_wr_id = '0;
    logic commit_req = 1'b0;
    logic sw_auth_ok = 1'b0;
    logic [1:0] sw_auth_lvl = '0;
    logic [1:0] level;
    logic [NK-1:0] key_have;
    logic resp_vld, resp_ok, legacy_en, block_en, blk_keyupd_en, blk_full_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    seclvl_ctrl #(.NUM_KEYS(NK), .KEY_ID_W(IW)) uut (
        .clk(clk), .rst_n(rst_n), .l3_card(l3_card),
        .key_wr_vld(key_wr_vld), .key_wr_id(key_wr_id),
        .commit_req(commit_req), .sw_auth_ok(sw_auth_ok), .sw_auth_lvl(sw_auth_lvl),
        .level(level), .key_have(key_have), .resp_vld(resp_vld), .resp_ok(resp_ok),
        .legacy_en(legacy_en), .block_en(block_en),
        .blk_keyupd_en(blk_keyupd_en), .blk_full_en(blk_full_en)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst_n = 1'b0;
        l3_card = strap;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_key(input int id);
        key_wr_vld = 1'b1;
        key_wr_id = IW'(id);
        @(negedge clk);
        key_wr_vld = 1'b0;
    endtask

    // strobe for one cycle; on return the verdict cycle is current
    task automatic commit_now();
        commit_req = 1'b1;
        @(negedge clk);
        commit_req = 1'b0;
    endtask

    task automatic switch_now(input int tgt);
        sw_auth_ok = 1'b1;
        sw_auth_lvl = 2'(tgt);
        @(negedge clk);
        sw_auth_ok = 1'b0;
    endtask

    task automatic chk_resp(input string tag, input int exp_ok);
        chk({tag, " resp_vld"}, int'(resp_vld), 1);
        chk({tag, " resp_ok"}, int'(resp_ok), exp_ok);
        @(negedge clk);
        chk({tag, " resp_vld drop"}, int'(resp_vld), 0);
    endtask

    task automatic chk_map(input int l);
        chk("R9 block_en", int'(block_en), 1);
        chk("R9 legacy_en", int'(legacy_en), (l != 3) ? 1 : 0);
        chk("R9 blk_keyupd_en", int'(blk_keyupd_en), (l != 1) ? 1 : 0);
        chk("R9 blk_full_en", int'(blk_full_en), (l == 0 || l == 3) ? 1 : 0);
    endtask

    // L1 card, all keys, commit to 1, then optional raise
    task automatic reach_l1(input int l);
        do_reset(1'b0);
        for (int k = 0; k < 4; k++) wr_key(k);
        commit_now();
        @(negedge clk);
        if (l > 1) begin
            switch_now(l);
            @(negedge clk);
        end
    endtask

    initial begin
        do_reset(1'b0);
        // R1 reset state
        chk("R1 level", int'(level), 0);
        chk("R1 key_have", int'(key_have), 0);
        chk("R1 resp_vld", int'(resp_vld), 0);
        chk("R1 resp_ok", int'(resp_ok), 0);
        chk_map(0);

        // R3 / R4 sweep over card variant and key subset
        for (int s = 0; s < 2; s++) begin
            for (int m = 0; m < 16; m++) begin
                int need, ok, tgt;
                do_reset(1'(s));
                for (int k = 0; k < 4; k++) if (m[k]) wr_key(k);
                chk("R7 key_have after writes", int'(key_have), m);
                need = (s == 1) ? 3 : 15;
                ok = ((m & need) == need) ? 1 : 0;
                tgt = (s == 1) ? 3 : 1;
                commit_now();
                chk(ok ? "R3 commit accepted" : "R4 commit missing key", int'(resp_ok), ok);
                chk("R3 level after commit", int'(level), ok ? tgt : 0);
                chk_resp("R8 commit", ok);
                if (ok) begin
                    chk_map(tgt);
                    // R2: second commit is not a raise
                    commit_now();
                    chk_resp("R2 repeat commit", 0);
                    chk("R2 level held", int'(level), tgt);
                    // R6: switches rejected on third-level card
                    if (s == 1) begin
                        for (int t = 0; t < 4; t++) begin
                            switch_now(t);
                            chk_resp("R6 l3 switch", 0);
                            chk("R6 level stays 3", int'(level), 3);
                        end
                    end
                end
            end
        end

        // R6: switch at level 0 on third-level card
        do_reset(1'b1);
        for (int t = 0; t < 4; t++) begin
            switch_now(t);
            chk_resp("R6 l3 switch at 0", 0);
            chk("R6 level stays 0", int'(level), 0);
        end

        // R5 / R2 sweep: start level x target on L1 card
        for (int st = 0; st < 4; st++) begin
            for (int t = 0; t < 4; t++) begin
                int ok;
                if (st == 0) do_reset(1'b0);
                else reach_l1(st);
                chk("R5 start level", int'(level), st);
                ok = (st >= 1 && t >= 2 && t > st) ? 1 : 0;
                switch_now(t);
                chk(ok ? "R5 switch accepted" : "R2 switch rejected", int'(resp_ok), ok);
                chk("R5 level after switch", int'(level), ok ? t : st);
                chk_resp("R8 switch", ok);
                chk_map(ok ? t : st);
            end
        end

        // R7: out-of-range ids ignored, flags sticky, frozen above 0
        do_reset(1'b0);
        wr_key(6);
        wr_key(4);
        chk("R7 out-of-range id", int'(key_have), 0);
        wr_key(1);
        wr_key(1);
        wr_key(7);
        chk("R7 sticky", int'(key_have), 2);
        wr_key(0); wr_key(2); wr_key(3);
        commit_now();
        chk("R7 commit level", int'(level), 1);
        @(negedge clk);
        do_reset(1'b1);
        wr_key(0); wr_key(1);
        commit_now();
        @(negedge clk);
        wr_key(2);
        wr_key(3);
        chk("R7 writes ignored above 0", int'(key_have), 3);

        // R8: simultaneous strobes give one rejection
        do_reset(1'b0);
        for (int k = 0; k < 4; k++) wr_key(k);
        commit_req = 1'b1;
        sw_auth_ok = 1'b1;
        sw_auth_lvl = 2'd3;
        @(negedge clk);
        commit_req = 1'b0;
        sw_auth_ok = 1'b0;
        chk("R8 conflict level", int'(level), 0);
        chk_resp("R8 conflict", 0);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule